// File: doc/BRIEF.md
# Control Register Update Unit

This unit holds a processor's architectural control state: the paging and protection register (CR0), the translation base register (CR3), the feature-control register (CR4), the extended-feature register (EFER) and the extended-state enable register (XCR0). A single write port selects one of them per cycle. Each accepted write is stored together with a recomputed word of hidden mode flags. The rest of the core reads that word instead of decoding several registers at once.

The unit also tells the translation cache when it must be flushed. It raises a one-cycle request only when a write changes bits that affect address translation. Feature-enable inputs decide which optional CR4 bits may be set, and gated bits are cleared silently before they are stored. Setting or clearing paging while long mode is enabled moves the core into or out of 64-bit long mode. On exit, the unit gives the fetch logic a one-cycle notice that the instruction pointer must be cut to 32 bits.

All results are registered. The stored values, the flag word and both pulses appear on the clock edge that follows the write cycle.

Top module: `ctlreg_update_unit`

## Requirements
- R1: A CR0 write (wr_sel=0) raises flush_req for exactly the cycle after the write, and only when bit 31 (PG), bit 16 (WP) or bit 0 (PE) of the stored value changes. Changes to any other CR0 bit raise no flush.
- R2: Bit 4 of cr0_o is 1 from reset onward, whatever is written. After reset cr0_o is 0x10 and all other registers are 0.
- R3: A CR0 write that sets PG from 0 while EFER bit 8 (LME) is 1 enters long mode only if CR4 bit 5 (PAE) is 1. Entering long mode sets EFER bit 10 (LMA) and hidden flag bit 5 (LMA). With PAE at 0 the write is dropped: CR0 is unchanged and there is no flush.
- R4: A CR0 write that clears PG while EFER.LMA is 1 clears EFER.LMA, hidden flag bit 5 (LMA) and hidden flag bit 6 (CS64). It also pulses ip_trunc for one cycle. ip_trunc stays 0 for every other write.
- R5: Hidden flag bit 0 equals CR0.PE. Hidden flag bit 1 (ADDSEG) is 1 whenever PE is 0 and 0 when PE is 1, so hflags_o is 0x002 after reset.
- R6: Hidden flag bits 4:2 hold CR0 bits 3:1 (TS, EM, MP) as one field.
- R7: A CR3 write (wr_sel=1) stores all of wr_data and raises flush_req only while CR0.PG is 1.
- R8: A CR4 write (wr_sel=2) raises flush_req only when stored bit 4 (PSE), 5 (PAE), 7 (PGE), 12 (LA57), 20 (SMEP) or 21 (SMAP) toggles.
- R9: For a CR4 write, a 0 on a feat_en bit clears the matching CR4 bit before it is stored: feat_en[0]→bit 9, [1]→bit 21, [2]→bit 11, [3]→bit 22, [4]→bit 24, [5]→bit 28. Hidden flag bits 7, 8 and 9 follow stored CR4 bits 9, 21 and 11.
- R10: Hidden flag bit 10 (vector-state enable) is 1 only when CR4 bit 18 is 1 and XCR0 bits 2 and 1 are both 1. It is recomputed on CR4 and XCR0 (wr_sel=4) writes.
- R11: An EFER write (wr_sel=3) stores wr_data. Hidden flag bit 5 takes EFER bit 10, and hidden flag bit 11 takes EFER bit 12.
- R12: A pulse on cs_ld sets hidden flag bit 6 (CS64) to cs_long AND the LMA flag.
- R13: When wr_valid is 0, or wr_sel is 5, 6 or 7, no register or flag changes and flush_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_sel | input | 3 | Target register: 0 CR0, 1 CR3, 2 CR4, 3 EFER, 4 XCR0 |
| wr_data | input | XLEN | Write value (CR0 and CR4 use bits 31:0) |
| feat_en | input | 6 | Feature-present inputs that gate CR4 bits |
| cs_ld | input | 1 | Code segment load strobe |
| cs_long | input | 1 | Long attribute of the loaded code segment |
| cr0_o | output | 32 | Stored CR0 |
| cr3_o | output | XLEN | Stored CR3 |
| cr4_o | output | 32 | Stored CR4 |
| efer_o | output | XLEN | Stored EFER |
| xcr0_o | output | XLEN | Stored XCR0 |
| hflags_o | output | 12 | Hidden mode flag word |
| flush_req | output | 1 | One-cycle translation cache flush request |
| ip_trunc | output | 1 | One-cycle notice to cut the instruction pointer to 32 bits |

## Verification
Every derived output comes from stored register state. A corrupted CR0, CR4 or EFER bit therefore shows up in hflags_o, and in how the next write is judged, on the first clock edge after the write that caused it. A wrong old value shows most clearly through flush_req. The bench compares that pulse against expected toggles, so a stale register produces a missing or extra flush on the next write to the same register. A wrong long-mode state shows as a dropped write that should land, as an LMA flag that disagrees with EFER bit 10, or as a missing ip_trunc pulse on the exit write.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int CRW = 32;

  typedef enum logic [2:0] {
    SEL_CR0  = 3'd0,
    SEL_CR3  = 3'd1,
    SEL_CR4  = 3'd2,
    SEL_EFER = 3'd3,
    SEL_XCR0 = 3'd4
  } reg_sel_e;

  // CR0 bit positions
  localparam int C0_PE = 0;
  localparam int C0_MP = 1;
  localparam int C0_TS = 3;
  localparam int C0_ET = 4;
  localparam int C0_WP = 16;
  localparam int C0_PG = 31;

  // CR4 bit positions
  localparam int C4_PSE     = 4;
  localparam int C4_PAE     = 5;
  localparam int C4_PGE     = 7;
  localparam int C4_OSFXSR  = 9;
  localparam int C4_UMIP    = 11;
  localparam int C4_LA57    = 12;
  localparam int C4_OSXSAVE = 18;
  localparam int C4_SMEP    = 20;
  localparam int C4_SMAP    = 21;
  localparam int C4_PKE     = 22;
  localparam int C4_PKS     = 24;
  localparam int C4_LAMSUP  = 28;

  // EFER and XCR0 bit positions
  localparam int EF_LME  = 8;
  localparam int EF_LMA  = 10;
  localparam int EF_SVME = 12;
  localparam int XC_SSE  = 1;
  localparam int XC_YMM  = 2;

  // Feature gating: feat_en[k] gates CR4 bit CR4_GATE_POS[k]
  localparam int FEAT_N = 6;
  localparam int unsigned CR4_GATE_POS [FEAT_N] =
    '{C4_OSFXSR, C4_SMAP, C4_UMIP, C4_PKE, C4_PKS, C4_LAMSUP};

  localparam logic [CRW-1:0] C0_ET_BIT = CRW'(1) << C0_ET;
  localparam logic [CRW-1:0] C0_FLUSH_MASK =
    (CRW'(1) << C0_PG) | (CRW'(1) << C0_WP) | (CRW'(1) << C0_PE);
  localparam logic [CRW-1:0] C4_FLUSH_MASK =
    (CRW'(1) << C4_PSE) | (CRW'(1) << C4_PAE) | (CRW'(1) << C4_PGE) |
    (CRW'(1) << C4_LA57) | (CRW'(1) << C4_SMEP) | (CRW'(1) << C4_SMAP);

  // Hidden flag word layout
  localparam int HF_PE     = 0;
  localparam int HF_ADDSEG = 1;
  localparam int HF_FPU_LO = 2;
  localparam int HF_FPU_HI = 4;
  localparam int HF_LMA    = 5;
  localparam int HF_CS64   = 6;
  localparam int HF_OSFXSR = 7;
  localparam int HF_SMAP   = 8;
  localparam int HF_UMIP   = 9;
  localparam int HF_AVX    = 10;
  localparam int HF_SVME   = 11;
  localparam int HF_W      = 12;

  localparam logic [HF_W-1:0] HF_RESET = HF_W'(1) << HF_ADDSEG;

endpackage

// File: rtl/ctlreg_cr0_path.sv
module ctlreg_cr0_path
  import ctlreg_pkg::*;
(
  input  logic           en,
  input  logic [CRW-1:0] cur,
  input  logic [CRW-1:0] new_val,
  input  logic           lme,
  input  logic           lma,
  input  logic           pae,
  output logic [CRW-1:0] nxt,
  output logic           lma_set,
  output logic           lma_clr,
  output logic           flush,
  output logic           ip_trunc
);

  logic pg_up, pg_down, enter, drop, accept;

  always_comb begin
    pg_up    = !cur[C0_PG] && new_val[C0_PG];
    pg_down  = cur[C0_PG] && !new_val[C0_PG];
    enter    = en && pg_up && lme;
    drop     = enter && !pae;
    accept   = en && !drop;
    lma_set  = enter && pae;
    lma_clr  = en && pg_down && lma;
    ip_trunc = lma_clr;
    flush    = accept && (((new_val ^ cur) & C0_FLUSH_MASK) != '0);
    nxt      = accept ? (new_val | C0_ET_BIT) : cur;
  end

endmodule

// File: rtl/ctlreg_cr4_filter.sv
module ctlreg_cr4_filter
  import ctlreg_pkg::*;
(
  input  logic              en,
  input  logic [CRW-1:0]    cur,
  input  logic [CRW-1:0]    new_val,
  input  logic [FEAT_N-1:0] feat_en,
  output logic [CRW-1:0]    nxt,
  output logic              flush
);

  logic [FEAT_N-1:0][CRW-1:0] clr_vec;
  logic [CRW-1:0]             clr_mask;
  logic [CRW-1:0]             gated;

  for (genvar k = 0; k < FEAT_N; k++) begin : g_gate
    assign clr_vec[k] = feat_en[k] ? '0 : (CRW'(1) << CR4_GATE_POS[k]);
  end

  always_comb begin
    clr_mask = '0;
    for (int k = 0; k < FEAT_N; k++) clr_mask = clr_mask | clr_vec[k];
    gated = new_val & ~clr_mask;
    nxt   = en ? gated : cur;
    flush = en && (((gated ^ cur) & C4_FLUSH_MASK) != '0);
  end

endmodule

// File: rtl/ctlreg_hflag_pack.sv
module ctlreg_hflag_pack
  import ctlreg_pkg::*;
(
  input  logic            pe,
  input  logic [2:0]      fpu_bits,
  input  logic            lma,
  input  logic            cs64,
  input  logic            osfxsr,
  input  logic            smap,
  input  logic            umip,
  input  logic            osxsave,
  input  logic [1:0]      xsave_en,
  input  logic            svme,
  output logic [HF_W-1:0] hf
);

  always_comb begin
    hf                       = '0;
    hf[HF_PE]                = pe;
    hf[HF_ADDSEG]            = !pe;
    hf[HF_FPU_HI:HF_FPU_LO]  = fpu_bits;
    hf[HF_LMA]               = lma;
    hf[HF_CS64]              = cs64;
    hf[HF_OSFXSR]            = osfxsr;
    hf[HF_SMAP]              = smap;
    hf[HF_UMIP]              = umip;
    hf[HF_AVX]               = osxsave && (xsave_en == 2'b11);
    hf[HF_SVME]              = svme;
  end

endmodule

// File: rtl/ctlreg_update_unit.sv
module ctlreg_update_unit
  import ctlreg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [2:0]        wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [FEAT_N-1:0] feat_en,
  input  logic              cs_ld,
  input  logic              cs_long,
  output logic [CRW-1:0]    cr0_o,
  output logic [XLEN-1:0]   cr3_o,
  output logic [CRW-1:0]    cr4_o,
  output logic [XLEN-1:0]   efer_o,
  output logic [XLEN-1:0]   xcr0_o,
  output logic [HF_W-1:0]   hflags_o,
  output logic              flush_req,
  output logic              ip_trunc
);

  logic [CRW-1:0]  cr0_q, cr4_q, cr0_n, cr4_n;
  logic [XLEN-1:0] cr3_q, efer_q, xcr0_q, cr3_n, efer_n, xcr0_n;
  logic [HF_W-1:0] hf_q, hf_n;
  logic            flush_q, trunc_q;

  logic wr_cr0, wr_cr3, wr_cr4, wr_efer, wr_xcr0;
  logic c0_lma_set, c0_lma_clr, c0_flush, c0_trunc, c4_flush;
  logic cs64_n;

  always_comb begin
    wr_cr0  = wr_valid && (wr_sel == SEL_CR0);
    wr_cr3  = wr_valid && (wr_sel == SEL_CR3);
    wr_cr4  = wr_valid && (wr_sel == SEL_CR4);
    wr_efer = wr_valid && (wr_sel == SEL_EFER);
    wr_xcr0 = wr_valid && (wr_sel == SEL_XCR0);
  end

  ctlreg_cr0_path u_cr0 (
    .en       (wr_cr0),
    .cur      (cr0_q),
    .new_val  (wr_data[CRW-1:0]),
    .lme      (efer_q[EF_LME]),
    .lma      (efer_q[EF_LMA]),
    .pae      (cr4_q[C4_PAE]),
    .nxt      (cr0_n),
    .lma_set  (c0_lma_set),
    .lma_clr  (c0_lma_clr),
    .flush    (c0_flush),
    .ip_trunc (c0_trunc)
  );

  ctlreg_cr4_filter u_cr4 (
    .en      (wr_cr4),
    .cur     (cr4_q),
    .new_val (wr_data[CRW-1:0]),
    .feat_en (feat_en),
    .nxt     (cr4_n),
    .flush   (c4_flush)
  );

  always_comb begin
    cr3_n  = wr_cr3 ? wr_data : cr3_q;
    xcr0_n = wr_xcr0 ? wr_data : xcr0_q;
    efer_n = efer_q;
    if (wr_efer)         efer_n = wr_data;
    else if (c0_lma_set) efer_n[EF_LMA] = 1'b1;
    else if (c0_lma_clr) efer_n[EF_LMA] = 1'b0;
    if (c0_lma_clr)      cs64_n = 1'b0;
    else if (cs_ld)      cs64_n = cs_long && efer_n[EF_LMA];
    else                 cs64_n = hf_q[HF_CS64];
  end

  ctlreg_hflag_pack u_pack (
    .pe       (cr0_n[C0_PE]),
    .fpu_bits (cr0_n[C0_TS:C0_MP]),
    .lma      (efer_n[EF_LMA]),
    .cs64     (cs64_n),
    .osfxsr   (cr4_n[C4_OSFXSR]),
    .smap     (cr4_n[C4_SMAP]),
    .umip     (cr4_n[C4_UMIP]),
    .osxsave  (cr4_n[C4_OSXSAVE]),
    .xsave_en (xcr0_n[XC_YMM:XC_SSE]),
    .svme     (efer_n[EF_SVME]),
    .hf       (hf_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0_q   <= C0_ET_BIT;
      cr3_q   <= '0;
      cr4_q   <= '0;
      efer_q  <= '0;
      xcr0_q  <= '0;
      hf_q    <= HF_RESET;
      flush_q <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      cr0_q   <= cr0_n;
      cr3_q   <= cr3_n;
      cr4_q   <= cr4_n;
      efer_q  <= efer_n;
      xcr0_q  <= xcr0_n;
      hf_q    <= hf_n;
      flush_q <= c0_flush || c4_flush || (wr_cr3 && cr0_q[C0_PG]);
      trunc_q <= c0_trunc;
    end
  end

  assign cr0_o     = cr0_q;
  assign cr3_o     = cr3_q;
  assign cr4_o     = cr4_q;
  assign efer_o    = efer_q;
  assign xcr0_o    = xcr0_q;
  assign hflags_o  = hf_q;
  assign flush_req = flush_q;
  assign ip_trunc  = trunc_q;

  // Checks next to the state they guard
  AST_ET_STUCK_ONE: assert property (@(posedge clk) disable iff (rst)
    cr0_q[C0_ET]); // R2

  AST_CR0_QUIET_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_cr0 && (((wr_data[CRW-1:0] ^ cr0_q) & C0_FLUSH_MASK) == '0)) |=> !flush_q); // R1

  AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(wr_valid)); // R13

  AST_LMA_ENTRY_PAE: assert property (@(posedge clk) disable iff (rst)
    ($rose(hf_q[HF_LMA]) && $past(wr_cr0)) |-> cr4_q[C4_PAE]); // R3

  AST_TRUNC_EXIT_STATE: assert property (@(posedge clk) disable iff (rst)
    trunc_q |-> (!efer_q[EF_LMA] && !hf_q[HF_LMA] && !hf_q[HF_CS64] && !cr0_q[C0_PG])); // R4

  AST_ADDSEG_REAL: assert property (@(posedge clk) disable iff (rst)
    !hf_q[HF_PE] |-> hf_q[HF_ADDSEG]); // R5

  AST_CR3_NO_PAGING: assert property (@(posedge clk) disable iff (rst)
    (wr_cr3 && !cr0_q[C0_PG]) |=> !flush_q); // R7

  AST_AVX_PRECOND: assert property (@(posedge clk) disable iff (rst)
    hf_q[HF_AVX] |-> (cr4_q[C4_OSXSAVE] && xcr0_q[XC_SSE] && xcr0_q[XC_YMM])); // R10

  AST_LMA_MATCHES_EFER: assert property (@(posedge clk) disable iff (rst)
    hf_q[HF_LMA] == efer_q[EF_LMA]); // R11

  for (genvar k = 0; k < FEAT_N; k++) begin : g_gate_chk
    AST_CR4_GATED: assert property (@(posedge clk) disable iff (rst)
      (wr_cr4 && !feat_en[k]) |=> !cr4_q[CR4_GATE_POS[k]]); // R9
  end

endmodule

// File: tb/ctlreg_update_unit_tb_top.sv
`timescale 1ns/1ps
module ctlreg_update_unit_tb_top;

  localparam int XLEN = 64;

  // Flag positions as stated in the requirements
  localparam int F_PE = 0, F_ADDSEG = 1, F_LMA = 5, F_CS64 = 6;
  localparam int F_OSFXSR = 7, F_SMAP = 8, F_UMIP = 9, F_AVX = 10, F_SVME = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_valid = 1'b0;
  logic [2:0]      wr_sel = 3'd0;
  logic [XLEN-1:0] wr_data = '0;
  logic [5:0]      feat_en = 6'h00;
  logic            cs_ld = 1'b0;
  logic            cs_long = 1'b0;
  logic [31:0]     cr0_o, cr4_o;
  logic [XLEN-1:0] cr3_o, efer_o, xcr0_o;
  logic [11:0]     hflags_o;
  logic            flush_req, ip_trunc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ctlreg_update_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .feat_en(feat_en), .cs_ld(cs_ld), .cs_long(cs_long),
    .cr0_o(cr0_o), .cr3_o(cr3_o), .cr4_o(cr4_o), .efer_o(efer_o), .xcr0_o(xcr0_o),
    .hflags_o(hflags_o), .flush_req(flush_req), .ip_trunc(ip_trunc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive one write; on return the registered results and pulses are visible
  task automatic do_wr(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_cs(input logic lng);
    @(negedge clk);
    cs_ld = 1'b1; cs_long = lng;
    @(negedge clk);
    cs_ld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 reset cr0", cr0_o, 64'h10);
    chk("R5 reset hflags", hflags_o, 64'h002);
    chk("R2 reset cr4", cr4_o, 0);
    chk("R2 reset efer", efer_o, 0);
    chk("R1 reset flush", flush_req, 0);
  endtask

  task automatic t_cr0_basic;
    do_wr(3'd0, 64'h0000_000E);
    chk("R2 cr0 et forced", cr0_o, 64'h1E);
    chk("R1 no flush on fpu bits", flush_req, 0);
    chk("R6 fpu field", hflags_o, 64'h01E);
    do_wr(3'd0, 64'h0000_0001);
    chk("R1 flush on PE", flush_req, 1);
    chk("R5 pe set addseg clear", hflags_o, 64'h001);
    @(negedge clk);
    chk("R1 flush single cycle", flush_req, 0);
    do_wr(3'd0, 64'h0001_0001);
    chk("R1 flush on WP", flush_req, 1);
    chk("R2 cr0 value", cr0_o, 64'h10011);
    do_wr(3'd0, 64'h0001_0001);
    chk("R1 no flush same value", flush_req, 0);
  endtask

  task automatic t_cr3_nopg;
    do_wr(3'd1, 64'h1234_5678_0000_1000);
    chk("R7 cr3 stored", cr3_o, 64'h1234_5678_0000_1000);
    chk("R7 no flush without paging", flush_req, 0);
  endtask

  task automatic t_cr4_gate;
    feat_en = 6'h00;
    do_wr(3'd2, 64'h1160_0A20);
    chk("R9 gated bits cleared", cr4_o, 64'h20);
    chk("R8 flush on PAE toggle", flush_req, 1);
    chk("R9 gated flags clear", hflags_o[F_UMIP:F_OSFXSR], 0);
    feat_en = 6'h3F;
    do_wr(3'd2, 64'h1160_0A20);
    chk("R9 bits kept with features", cr4_o, 64'h1160_0A20);
    chk("R8 flush on SMAP toggle", flush_req, 1);
    chk("R9 flags follow cr4", hflags_o[F_UMIP:F_OSFXSR], 3'b111);
    do_wr(3'd2, 64'h1160_0820);
    chk("R8 no flush on OSFXSR only", flush_req, 0);
    chk("R9 osfxsr flag off", hflags_o[F_OSFXSR], 0);
    feat_en = 6'h3E;
    do_wr(3'd2, 64'h1160_0A20);
    chk("R9 sse feature gates bit 9", cr4_o, 64'h1160_0820);
    feat_en = 6'h3F;
  endtask

  task automatic t_avx;
    do_wr(3'd2, 64'h1164_0A20);
    chk("R8 no flush on OSXSAVE", flush_req, 0);
    chk("R10 avx off without xcr0", hflags_o[F_AVX], 0);
    do_wr(3'd4, 64'h3);
    chk("R10 avx off without ymm", hflags_o[F_AVX], 0);
    do_wr(3'd4, 64'h7);
    chk("R10 avx on", hflags_o[F_AVX], 1);
    chk("R10 xcr0 stored", xcr0_o, 64'h7);
    do_wr(3'd2, 64'h1160_0A20);
    chk("R10 avx off after OSXSAVE clear", hflags_o[F_AVX], 0);
  endtask

  task automatic t_long_entry;
    do_wr(3'd2, 64'h1160_0A00);
    chk("R8 flush on PAE clear", flush_req, 1);
    do_wr(3'd3, 64'h100);
    chk("R11 efer stored", efer_o, 64'h100);
    chk("R11 lma flag off", hflags_o[F_LMA], 0);
    do_wr(3'd0, 64'h8001_0001);
    chk("R3 dropped cr0", cr0_o, 64'h10011);
    chk("R3 dropped no flush", flush_req, 0);
    chk("R3 dropped no lma", efer_o, 64'h100);
    do_wr(3'd2, 64'h1160_0A20);
    do_wr(3'd0, 64'h8001_0001);
    chk("R3 cr0 paging on", cr0_o, 64'h8001_0011);
    chk("R1 flush on PG", flush_req, 1);
    chk("R3 efer lma set", efer_o, 64'h500);
    chk("R3 lma flag set", hflags_o[F_LMA], 1);
    chk("R4 no trunc on entry", ip_trunc, 0);
  endtask

  task automatic t_paged;
    do_wr(3'd1, 64'h2000);
    chk("R7 flush with paging", flush_req, 1);
    do_cs(1'b1);
    chk("R12 cs64 set in long mode", hflags_o[F_CS64], 1);
  endtask

  task automatic t_long_exit;
    do_wr(3'd0, 64'h0001_0001);
    chk("R4 trunc pulse", ip_trunc, 1);
    chk("R1 flush on PG clear", flush_req, 1);
    chk("R4 efer lma cleared", efer_o, 64'h100);
    chk("R4 lma flag cleared", hflags_o[F_LMA], 0);
    chk("R4 cs64 cleared", hflags_o[F_CS64], 0);
    @(negedge clk);
    chk("R4 trunc single cycle", ip_trunc, 0);
    do_cs(1'b1);
    chk("R12 cs64 stays off outside long mode", hflags_o[F_CS64], 0);
  endtask

  task automatic t_efer;
    do_wr(3'd3, 64'h1500);
    chk("R11 lma flag from efer", hflags_o[F_LMA], 1);
    chk("R11 svme flag from efer", hflags_o[F_SVME], 1);
    do_wr(3'd3, 64'h0);
    chk("R11 flags clear", {hflags_o[F_SVME], hflags_o[F_LMA]}, 0);
  endtask

  task automatic t_ignored;
    logic [11:0] hf0;
    logic [63:0] c3;
    hf0 = hflags_o; c3 = cr3_o;
    @(negedge clk);
    wr_valid = 1'b0; wr_sel = 3'd1; wr_data = 64'hDEAD;
    repeat (2) @(negedge clk);
    chk("R13 no write when invalid", cr3_o, c3);
    chk("R13 no flush when invalid", flush_req, 0);
    do_wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R13 sel5 cr0", cr0_o, 64'h10011);
    chk("R13 sel5 cr4", cr4_o, 64'h1160_0A20);
    chk("R13 sel5 hflags", hflags_o, hf0);
    chk("R13 sel5 no flush", flush_req, 0);
    do_wr(3'd7, 64'h0);
    chk("R13 sel7 cr3", cr3_o, c3);
    chk("R13 sel7 efer", efer_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cr0_basic();
    t_cr3_nopg();
    t_cr4_gate();
    t_avx();
    t_long_entry();
    t_paged();
    t_long_exit();
    t_efer();
    t_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule